// File: doc/BRIEF.md
# Adaptive Gate Non-Overlap Sequencer

This block turns one pulse-width command into two gate-enable outputs, one for the high-side switch and one for the low-side switch, and makes sure the two are never on together. It does not use a fixed dead time. Before it turns a gate on, it waits until a comparator reports that the opposite gate has actually fallen below its turn-on threshold. It then adds a programmable minimum delay, counted in clock cycles. A gate that discharges slowly therefore makes the dead time longer by exactly the extra time it takes to fall.

Three side inputs change the basic alternation:
- A force-off input from the fault logic pulls both gates low.
- A low-side inhibit input from the light-load logic keeps the low side off, so that reverse inductor current is blocked.
- A toggle mode, used once an overvoltage latch-off has occurred, keeps the high side off for good. In this mode the low side switches from a hysteresis latch that follows two output-voltage threshold flags.

If the command changes while a turn-on is still pending, the pending turn-on is dropped and the new request is served instead.

Top module: `gate_nonoverlap_seq`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle.
- R2: `hs_on` rises only after `ls_sense_hi` has been sampled low on `HS_DLY` consecutive clock edges. With `ls_sense_hi` already low, `hs_on` is high after the (`HS_DLY`+1)-th edge that sees `pwm_cmd`=1, counting from an idle or low-side-on state. The default `HS_DLY` is 2.
- R3: `ls_on` rises only after `hs_sense_hi` has been sampled low on `LS_DLY` consecutive clock edges. The same (`LS_DLY`+1)-edge latency applies. The default `LS_DLY` is 3.
- R4: Any edge that samples the opposite sense bit high restarts the minimum-delay count. The dead time therefore stretches by the time the falling gate stays above threshold.
- R5: If `pwm_cmd` changes while a turn-on is pending, that turn-on never happens. The other side's wait starts from zero.
- R6: When `pwm_cmd` falls, `hs_on` is low after the next edge. When `pwm_cmd` rises, `ls_on` is low after the next edge.
- R7: While `force_off`=1, both outputs are low after each edge. When it is released, the normal delayed turn-on applies.
- R8: With `ls_inhibit`=1 and `ls_toggle_mode`=0, `ls_on` stays low. The high-side turn-on still waits for `ls_sense_hi` to be low.
- R9: With `ls_toggle_mode`=1, `hs_on` stays low regardless of `pwm_cmd`. An internal latch is set by `ov_high`=1 and cleared by `ov_low`=1. While the latch is set, the low side is requested, subject to the R3 delay. `ls_inhibit` is ignored in this mode.
- R10: Asserting `rst_n` low drives both outputs low at once and clears the hysteresis latch. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd | input | 1 | 1 requests the high side, 0 requests the low side |
| hs_sense_hi | input | 1 | High-side gate still above turn-on threshold |
| ls_sense_hi | input | 1 | Low-side gate still above turn-on threshold |
| ls_inhibit | input | 1 | Keep low side off (light-load mode) |
| force_off | input | 1 | Fault request: both gates off |
| ls_toggle_mode | input | 1 | Post-overvoltage mode: high side off, low side from hysteresis |
| ov_high | input | 1 | Output above upper overvoltage threshold (sets latch) |
| ov_low | input | 1 | Output below lower overvoltage threshold (clears latch) |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Some rules are checked by assertions on every cycle:
- mutual exclusion of the two outputs;
- that each rising output was preceded by a low sense sample of the opposite gate;
- that force-off, inhibit, toggle mode and a falling command each clear the affected output one edge later.

Other behaviours appear only in the bench's timed scenarios:
- the exact dead-time length;
- the restart of the count when a sense bit bounces high;
- the abort of a pending turn-on;
- the hysteresis set/clear order and the clearing of the latch by reset.

// File: rtl/nov_pkg.sv
package nov_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_WAIT_HS = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_WAIT_LS = 3'd3,
    ST_LS_ON   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/nov_request.sv
module nov_request
  import nov_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwm_cmd,
  input  logic  ls_inhibit,
  input  logic  force_off,
  input  logic  ls_toggle_mode,
  input  logic  ov_high,
  input  logic  ov_low,
  output side_e want
);

  logic hyst_q;
  logic hyst_d;
  logic hyst_en;

  // Hysteresis latch: lower threshold clears, upper threshold sets.
  always_comb begin
    hyst_en = ov_low | ov_high;
    hyst_d  = ~ov_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_q <= 1'b0;
    end else if (hyst_en) begin
      hyst_q <= hyst_d;
    end
  end

  always_comb begin
    want = SIDE_NONE;
    if (!force_off) begin
      if (ls_toggle_mode) begin
        if (hyst_q) want = SIDE_LO;
      end else if (pwm_cmd) begin
        want = SIDE_HI;
      end else if (!ls_inhibit) begin
        want = SIDE_LO;
      end
    end
  end

  AST_TOGGLE_NEVER_HI: assert property (@(posedge clk) disable iff (!rst_n) ls_toggle_mode |-> (want != SIDE_HI)); // R9

endmodule

// File: rtl/nov_delay_timer.sv
module nov_delay_timer #(
  parameter int LIM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  localparam int CW = (LIM < 2) ? 1 : $clog2(LIM + 1);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = run & ~clr & (cnt_q == LAST);
    cnt_en = 1'b1;
    if (clr | ~run | done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cnt_q <= LAST)); // R4

endmodule

// File: rtl/gate_nonoverlap_seq.sv
module gate_nonoverlap_seq
  import nov_pkg::*;
#(
  parameter int HS_DLY = 2,
  parameter int LS_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic hs_sense_hi,
  input  logic ls_sense_hi,
  input  logic ls_inhibit,
  input  logic force_off,
  input  logic ls_toggle_mode,
  input  logic ov_high,
  input  logic ov_low,
  output logic hs_on,
  output logic ls_on
);

  localparam int NSIDE = 2;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  side_e want;

  nov_request u_req (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .pwm_cmd        (pwm_cmd),
    .ls_inhibit     (ls_inhibit),
    .force_off      (force_off),
    .ls_toggle_mode (ls_toggle_mode),
    .ov_high        (ov_high),
    .ov_low         (ov_low),
    .want           (want)
  );

  seq_state_e st_q;
  seq_state_e st_d;
  logic       st_en;

  logic [NSIDE-1:0] tmr_clr;
  logic [NSIDE-1:0] tmr_run;
  logic [NSIDE-1:0] tmr_done;

  // Index 0 guards high-side turn-on, index 1 guards low-side turn-on.
  always_comb begin
    tmr_clr[0] = (st_q != ST_WAIT_HS);
    tmr_run[0] = ~ls_sense_hi;
    tmr_clr[1] = (st_q != ST_WAIT_LS);
    tmr_run[1] = ~hs_sense_hi;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_tmr
    localparam int LIM_G = (g == 0) ? HS_DLY : LS_DLY;
    nov_delay_timer #(.LIM(LIM_G)) u_tmr (
      .clk   (clk),
      .rst_n (rst_i_n),
      .clr   (tmr_clr[g]),
      .run   (tmr_run[g]),
      .done  (tmr_done[g])
    );
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF: begin
        if (want == SIDE_HI)      st_d = ST_WAIT_HS;
        else if (want == SIDE_LO) st_d = ST_WAIT_LS;
      end
      ST_WAIT_HS: begin
        if (want == SIDE_LO)        st_d = ST_WAIT_LS;
        else if (want == SIDE_NONE) st_d = ST_OFF;
        else if (tmr_done[0])       st_d = ST_HS_ON;
      end
      ST_HS_ON: begin
        if (want == SIDE_LO)        st_d = ST_WAIT_LS;
        else if (want == SIDE_NONE) st_d = ST_OFF;
      end
      ST_WAIT_LS: begin
        if (want == SIDE_HI)        st_d = ST_WAIT_HS;
        else if (want == SIDE_NONE) st_d = ST_OFF;
        else if (tmr_done[1])       st_d = ST_LS_ON;
      end
      ST_LS_ON: begin
        if (want == SIDE_HI)        st_d = ST_WAIT_HS;
        else if (want == SIDE_NONE) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_OFF;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign hs_on = (st_q == ST_HS_ON);
  assign ls_on = (st_q == ST_LS_ON);

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_i_n) !(hs_on && ls_on)); // R1
  AST_HS_AFTER_LS_OFF: assert property (@(posedge clk) disable iff (!rst_i_n) $rose(hs_on) |-> $past(!ls_on)); // R1
  AST_HS_NEEDS_LS_LOW: assert property (@(posedge clk) disable iff (!rst_i_n) $rose(hs_on) |-> $past(!ls_sense_hi)); // R2
  AST_LS_NEEDS_HS_LOW: assert property (@(posedge clk) disable iff (!rst_i_n) $rose(ls_on) |-> $past(!hs_sense_hi)); // R3
  AST_PWM_FALL_DROPS_HS: assert property (@(posedge clk) disable iff (!rst_i_n) !pwm_cmd |=> !hs_on); // R6
  AST_FORCE_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_i_n) force_off |=> (!hs_on && !ls_on)); // R7
  AST_INHIBIT_HOLDS_LS: assert property (@(posedge clk) disable iff (!rst_i_n) (ls_inhibit && !ls_toggle_mode) |=> !ls_on); // R8
  AST_TOGGLE_HS_OFF: assert property (@(posedge clk) disable iff (!rst_i_n) ls_toggle_mode |=> !hs_on); // R9

endmodule

// File: tb/tb_gate_nonoverlap_seq.sv
module tb_gate_nonoverlap_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_cmd, hs_sense_hi, ls_sense_hi, ls_inhibit, force_off;
  logic ls_toggle_mode, ov_high, ov_low;
  logic hs_on, ls_on;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gate_nonoverlap_seq #(.HS_DLY(2), .LS_DLY(3)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwm_cmd        (pwm_cmd),
    .hs_sense_hi    (hs_sense_hi),
    .ls_sense_hi    (ls_sense_hi),
    .ls_inhibit     (ls_inhibit),
    .force_off      (force_off),
    .ls_toggle_mode (ls_toggle_mode),
    .ov_high        (ov_high),
    .ov_low         (ov_low),
    .hs_on          (hs_on),
    .ls_on          (ls_on)
  );

  // Row: {pwm, hs_sense, ls_sense, inhibit, force_off, toggle, ov_high, ov_low}, {exp_hs, exp_ls}, req
  // Expected values hold after the clock edge that samples the row.
  localparam int NV = 46;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {8'b00000000, 2'b00, 4'd3},  // R3 low side waits 3 edges after request
    {8'b00000000, 2'b00, 4'd3},
    {8'b00000000, 2'b00, 4'd3},
    {8'b00000000, 2'b01, 4'd3},
    {8'b10100000, 2'b00, 4'd6},  // R6 ls drops on pwm rise
    {8'b10100000, 2'b00, 4'd4},  // R4 ls still sensed high
    {8'b10100000, 2'b00, 4'd4},
    {8'b10000000, 2'b00, 4'd2},  // R2
    {8'b10000000, 2'b10, 4'd2},
    {8'b11000000, 2'b10, 4'd2},
    {8'b01000000, 2'b00, 4'd6},  // R6 hs drops on pwm fall
    {8'b01000000, 2'b00, 4'd4},
    {8'b00000000, 2'b00, 4'd3},
    {8'b00000000, 2'b00, 4'd3},
    {8'b00000000, 2'b01, 4'd3},
    {8'b10100000, 2'b00, 4'd5},  // R5 abort of pending hs
    {8'b10000000, 2'b00, 4'd5},
    {8'b00000000, 2'b00, 4'd5},
    {8'b00000000, 2'b00, 4'd5},
    {8'b00000000, 2'b00, 4'd5},
    {8'b00000000, 2'b01, 4'd3},
    {8'b00001000, 2'b00, 4'd7},  // R7 force off
    {8'b10001000, 2'b00, 4'd7},
    {8'b10001000, 2'b00, 4'd7},
    {8'b10000000, 2'b00, 4'd2},
    {8'b10000000, 2'b00, 4'd2},
    {8'b10000000, 2'b10, 4'd2},
    {8'b01010000, 2'b00, 4'd8},  // R8 inhibit keeps ls off
    {8'b00010000, 2'b00, 4'd8},
    {8'b00010000, 2'b00, 4'd8},
    {8'b00010000, 2'b00, 4'd8},
    {8'b00010000, 2'b00, 4'd8},
    {8'b10110000, 2'b00, 4'd8},  // R8 hs still waits for ls sense
    {8'b10110000, 2'b00, 4'd8},
    {8'b10010000, 2'b00, 4'd8},
    {8'b10010000, 2'b10, 4'd8},
    {8'b11000100, 2'b00, 4'd9},  // R9 toggle mode: hs forced off
    {8'b11000110, 2'b00, 4'd9},
    {8'b11000100, 2'b00, 4'd9},
    {8'b11000100, 2'b00, 4'd9},
    {8'b10000100, 2'b00, 4'd9},
    {8'b10000100, 2'b00, 4'd9},
    {8'b10000100, 2'b01, 4'd9},
    {8'b10000101, 2'b01, 4'd9},
    {8'b10000100, 2'b00, 4'd9},
    {8'b10000100, 2'b00, 4'd9}
  };

  task automatic check2(input int req, input logic eh, input logic el);
    total++;
    if (hs_on !== eh || ls_on !== el) begin
      bad++;
      $display("FAIL R%0d: hs_on/ls_on=%b%b expected %b%b", req, hs_on, ls_on, eh, el);
    end
  endtask

  task automatic check_r1();
    total++;
    if (hs_on === 1'b1 && ls_on === 1'b1) begin
      bad++;
      $display("FAIL R1: hs_on/ls_on=%b%b expected not 11", hs_on, ls_on);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {pwm_cmd, hs_sense_hi, ls_sense_hi, ls_inhibit, force_off, ls_toggle_mode, ov_high, ov_low} = v;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(8'b00001000);
    #1;
    check2(10, 1'b0, 1'b0);  // R10 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][13:6]);
      step();
      check2(int'(VEC[i][3:0]), VEC[i][5], VEC[i][4]);
      check_r1();
    end

    // R9: hysteresis set brings low side on in toggle mode
    @(negedge clk); drive(8'b10000110);
    @(negedge clk); drive(8'b10000100);
    repeat (6) @(negedge clk);
    #1;
    check2(9, 1'b0, 1'b1);

    // R10: asynchronous clear, then latch stays cleared after release
    rst_n = 1'b0;
    #2;
    check2(10, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(8'b00000100);
    repeat (10) @(negedge clk);
    check2(10, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule